// File: doc/BRIEF.md
# Periodic Clock-Pulse Inhibition Calibrator

This block trims the rate of a watch timebase. It runs on the reference clock and receives the 8192 Hz stage of the divider chain as a one-cycle strobe. At the start of each calibration window it deletes a programmed number of consecutive strobes, then passes all the others unchanged. Over a whole window the corrected stream loses exactly the programmed count. The window is either a short or a long span of input strobes, selected by the configuration word. By default these spans are one minute (491520 strobes) and two minutes (983040 strobes).

The configuration word is read only when a window closes, so software or storage may change it at any time without corrupting the current window. A one-cycle marker shows where each new window begins, so that a measurement setup can count strobes between two markers.

Top module: `pulse_trim_cal`

## Requirements
- R1: When no deletion is pending, `tick_out` equals `tick_in` in the same cycle, and `tick_out` is never high while `tick_in` is low.
- R2: The deletion count N is `cfg_word[7:1]` read as an unsigned number with `cfg_word[7]` as its most significant bit. After a window boundary, the next N strobes of `tick_in` are removed from `tick_out`.
- R3: When N is zero, no strobe is removed in that window.
- R4: When `cfg_word[0]` is 0 the window is LEN_SHORT input strobes long. When it is 1 the window is LEN_LONG strobes long.
- R5: `cfg_word` is sampled only on the strobe that closes a window. Changes during a window have no effect on that window's length or deletion count.
- R6: `period_mark` is high for exactly one cycle: the cycle after the strobe that closes a window. It is low in every other cycle.
- R7: A synchronous reset clears the window position, the pending deletion count and the marker, and selects the short window. The first window after reset is short and removes nothing.
- R8: Removed strobes still advance the window position. Each window therefore spans its full length of input strobes and removes exactly N of them.
- R9: Cycles in which `tick_in` is low do not advance the window position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_in | input | 1 | One-cycle strobe of the 8192 Hz stage |
| cfg_word | input | 8 | Bits 7..1: deletion count with bit 7 as MSB; bit 0: window select |
| tick_out | output | 1 | Corrected strobe stream |
| period_mark | output | 1 | One-cycle marker at the start of each window |

## Verification
The bench counts the strobes and removals between successive markers. A design that skipped removed strobes when counting, or that counted idle cycles, would show windows that are too long or too short. Back-to-back strobes right after a boundary catch a design that starts deleting one strobe late or stops one early, and the field values 0, 1, 64 and 127 catch a reversed bit order or a design that deletes something when N is zero. The configuration is changed in the middle of windows, so a design that reads the word continuously would show the wrong count or length. A reset in the middle of a run checks that the short, uncorrected first window is restored.

// File: rtl/pulse_trim_pkg.sv
package pulse_trim_pkg;
  localparam int CFG_W = 8;
  localparam int NUM_W = CFG_W - 1;

  typedef enum logic {
    WIN_SHORT = 1'b0,
    WIN_LONG  = 1'b1
  } win_e;

  // Deletion count: upper seven bits, top bit most significant
  function automatic logic [NUM_W-1:0] drop_count(input logic [CFG_W-1:0] w);
    return w[CFG_W-1:1];
  endfunction

  // Window selection from the lowest bit
  function automatic win_e win_select(input logic [CFG_W-1:0] w);
    return win_e'(w[0]);
  endfunction
endpackage

// File: rtl/pulse_trim_timer.sv
module pulse_trim_timer
  import pulse_trim_pkg::*;
#(
  parameter int LEN_SHORT = 491520,
  parameter int LEN_LONG  = 983040,
  parameter int POS_W     = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_in,
  input  win_e             win,
  output logic [POS_W-1:0] pos,
  output logic             wrap
);
  localparam logic [POS_W-1:0] LAST_S = POS_W'(LEN_SHORT - 1);
  localparam logic [POS_W-1:0] LAST_L = POS_W'(LEN_LONG - 1);

  function automatic logic [POS_W-1:0] last_pos(input win_e w);
    return (w == WIN_LONG) ? LAST_L : LAST_S;
  endfunction

  logic [POS_W-1:0] pos_q;

  assign wrap = tick_in && (pos_q == last_pos(win));
  assign pos  = pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
    end else if (wrap) begin
      pos_q <= '0;
    end else if (tick_in) begin
      pos_q <= pos_q + POS_W'(1);
    end
  end
endmodule

// File: rtl/pulse_trim_drop.sv
module pulse_trim_drop #(
  parameter int NUM_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_in,
  input  logic             load,
  input  logic [NUM_W-1:0] load_val,
  output logic             busy
);
  logic [NUM_W-1:0] left_q;

  assign busy = (left_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (load) begin
      left_q <= load_val;
    end else if (tick_in && busy) begin
      left_q <= left_q - NUM_W'(1);
    end
  end
endmodule

// File: rtl/pulse_trim_gate.sv
module pulse_trim_gate (
  input  logic tick_in,
  input  logic busy,
  output logic tick_out
);
  assign tick_out = tick_in && !busy;
endmodule

// File: rtl/pulse_trim_cal.sv
module pulse_trim_cal
  import pulse_trim_pkg::*;
#(
  parameter int LEN_SHORT = 491520,
  parameter int LEN_LONG  = 983040
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_in,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             tick_out,
  output logic             period_mark
);
  localparam int POS_W = $clog2(LEN_LONG);

  win_e             win_q;
  logic             mark_q;
  logic [POS_W-1:0] pos;
  logic             wrap;
  logic             drop_busy;

  pulse_trim_timer #(
    .LEN_SHORT(LEN_SHORT),
    .LEN_LONG (LEN_LONG),
    .POS_W    (POS_W)
  ) timer_i (
    .clk    (clk),
    .rst    (rst),
    .tick_in(tick_in),
    .win    (win_q),
    .pos    (pos),
    .wrap   (wrap)
  );

  pulse_trim_drop #(
    .NUM_W(NUM_W)
  ) drop_i (
    .clk     (clk),
    .rst     (rst),
    .tick_in (tick_in),
    .load    (wrap),
    .load_val(drop_count(cfg_word)),
    .busy    (drop_busy)
  );

  pulse_trim_gate gate_i (
    .tick_in (tick_in),
    .busy    (drop_busy),
    .tick_out(tick_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q  <= WIN_SHORT;
      mark_q <= 1'b0;
    end else begin
      mark_q <= wrap;
      if (wrap) begin
        win_q <= win_select(cfg_word);
      end
    end
  end

  assign period_mark = mark_q;
endmodule

// File: rtl/pulse_trim_chk.sv
module pulse_trim_chk #(
  parameter int POS_W = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_in,
  input logic [7:0]       cfg_word,
  input logic             tick_out,
  input logic             period_mark,
  input logic             wrap,
  input logic             drop_busy,
  input logic [POS_W-1:0] pos
);
  // R1
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_in && !drop_busy) |-> tick_out);

  // R1
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    tick_out |-> tick_in);

  // R2
  first_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (period_mark && tick_in && ($past(cfg_word[7:1]) != 7'd0)) |-> !tick_out);

  // R3
  zero_count_chk: assert property (@(posedge clk) disable iff (rst)
    (period_mark && ($past(cfg_word[7:1]) == 7'd0)) |-> (tick_out == tick_in));

  // R6
  mark_follow_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> period_mark);

  // R6
  mark_single_chk: assert property (@(posedge clk) disable iff (rst)
    period_mark |=> !period_mark);

  // R7
  reset_mark_chk: assert property (@(posedge clk)
    rst |=> !period_mark);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_in |=> $stable(pos));
endmodule

bind pulse_trim_cal pulse_trim_chk #(.POS_W(POS_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .tick_in    (tick_in),
  .cfg_word   (cfg_word),
  .tick_out   (tick_out),
  .period_mark(period_mark),
  .wrap       (wrap),
  .drop_busy  (drop_busy),
  .pos        (pos)
);

// File: tb/pulse_trim_cal_tb_top.sv
module pulse_trim_cal_tb_top;
  localparam int LS = 150;
  localparam int LL = 300;
  localparam int NC = 14000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_in = 1'b0;
  logic [7:0] cfg = 8'h00;
  wire        tick_out;
  wire        period_mark;

  always #2 clk = ~clk;

  pulse_trim_cal #(.LEN_SHORT(LS), .LEN_LONG(LL)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .tick_in    (tick_in),
    .cfg_word   (cfg),
    .tick_out   (tick_out),
    .period_mark(period_mark)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // reference model state
  int mpos, mrem, mn;
  bit msel, mmark, just_rst, cfg_moved, have_mark;
  int cnt_p, cnt_s, exp_len, exp_n;
  string tag;

  logic [7:0] pats [8] = '{8'h00, 8'hFE, 8'h02, 8'h81, 8'hFF, 8'h80, 8'h01, 8'h7E};

  function automatic int len_of(bit s);
    return s ? LL : LS;
  endfunction

  // R2: field is bits 7..1, bit 7 most significant
  function automatic int field_n(logic [7:0] w);
    return int'(w[7:1]);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  initial begin
    void'($urandom(32'd4321));
    for (int cyc = 0; cyc < NC; cyc++) begin
      @(negedge clk);
      rst = (cyc < 3) || (cyc >= 7000 && cyc < 7003);
      tick_in = (cyc < 3000) ? 1'b1 : (($urandom % 3) == 0);
      if (($urandom % 150) == 0) begin
        cfg = ($urandom % 2) ? pats[$urandom % 8] : 8'($urandom);
        cfg_moved = 1'b1;
      end
      #1;
      if (rst) begin
        mpos = 0; mrem = 0; mn = 0; msel = 1'b0; mmark = 1'b0;
        just_rst = 1'b1;
        // R7: first window after reset is short with no deletion
        have_mark = 1'b1; exp_len = LS; exp_n = 0;
        cnt_p = 0; cnt_s = 0; cfg_moved = 1'b0;
      end else begin
        tag = (mrem != 0) ? "R2" : (just_rst ? "R7" : "R1");
        chk(tick_out == (tick_in && mrem == 0), tag, int'(tick_out), int'(tick_in && mrem == 0));
        chk(period_mark == mmark, just_rst ? "R7" : "R6", int'(period_mark), int'(mmark));
        just_rst = 1'b0;
        if (period_mark) begin
          if (have_mark) begin
            chk(cnt_p == exp_len, "R4/R9", cnt_p, exp_len);
            tag = (exp_n == 0) ? "R3" : (cfg_moved ? "R5" : "R8");
            chk(cnt_s == exp_n, tag, cnt_s, exp_n);
          end
          have_mark = 1'b1;
          cnt_p = 0; cnt_s = 0; cfg_moved = 1'b0;
          exp_len = len_of(msel);
          exp_n = mn;
        end
        if (tick_in) cnt_p++;
        if (tick_in && !tick_out) cnt_s++;
        // model advance for the coming edge
        mmark = 1'b0;
        if (tick_in) begin
          if (mrem != 0) mrem--;
          if (mpos == len_of(msel) - 1) begin
            mpos = 0;
            mn = field_n(cfg);
            mrem = mn;
            msel = cfg[0];
            mmark = 1'b1;
          end else begin
            mpos++;
          end
        end
      end
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule